// File: doc/BRIEF.md
# Complex Add/Subtract Unit with Quarter-Turn Rotation

This block combines two complex operands, each carried as a signed 20-bit real part and a signed 20-bit imaginary part, into one complex result. A 2-bit operation code picks plain addition, plain subtraction, or addition or subtraction of the second operand after it has been turned a quarter turn, that is, multiplied by j. The quarter turn uses no multiplier. Each output lane takes its addend from either the real or the imaginary part of the second operand and may negate it.

Each lane sums at 21 bits, so no carry is lost. The result is then clamped to the signed 20-bit range instead of wrapping, and a flag reports any clamp. By default a single output register holds the result, the flag and a valid bit. The register has a synchronous active-high reset. A parameter removes the register for purely combinational use.

Top module: `cplx_addsub_rot`

## Requirements
- R1: With op = 2'b00, real_out = real_1 + real_2 and imag_out = imag_1 + imag_2.
- R2: With op = 2'b01, real_out = real_1 - real_2 and imag_out = imag_1 - imag_2.
- R3: With op = 2'b10 (first plus j times second), real_out = real_1 - imag_2 and imag_out = imag_1 + real_2.
- R4: With op = 2'b11 (first minus j times second), real_out = real_1 + imag_2 and imag_out = imag_1 - real_2.
- R5: A component whose exact result exceeds 524287 is output as 524287.
- R6: A component whose exact result is below -524288 is output as -524288.
- R7: overflow is 1 exactly when at least one component of the same result was clamped, and 0 otherwise.
- R8: With the output register enabled (default), results and overflow appear one rising clock edge after the inputs are sampled. out_valid at that point equals the in_valid sampled at that edge.
- R9: While rst is high at a rising edge, that edge sets real_out, imag_out, overflow and out_valid to zero.
- R10: Negating the most negative operand value does not wrap. For example, 0 - (-524288) gives 524287 with overflow set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the current operands as valid |
| op | input | 2 | Operation: 00 add, 01 subtract, 10 add j·C2, 11 subtract j·C2 |
| real_1 | input | 20 | First operand, real part (signed) |
| imag_1 | input | 20 | First operand, imaginary part (signed) |
| real_2 | input | 20 | Second operand, real part (signed) |
| imag_2 | input | 20 | Second operand, imaginary part (signed) |
| real_out | output | 20 | Result, real part (signed, clamped) |
| imag_out | output | 20 | Result, imaginary part (signed, clamped) |
| overflow | output | 1 | Set when either result component was clamped |
| out_valid | output | 1 | Registered copy of in_valid |

## Verification
Every result, its overflow flag and its valid bit are due exactly one rising edge after the operands are applied. A reset takes effect on the first edge it is high. The bench drives each new vector on a falling edge. On the next falling edge it compares all four outputs against the values it computed for that vector, then drives the next one, so each check looks at exactly one register stage. The sweep covers every operation across all combinations of eight boundary and interior values per operand component, which reaches both clamp limits in each lane.

// File: rtl/cplx_pkg.sv
package cplx_pkg;

    localparam int unsigned DW = 20;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_ADDJ = 2'b10,
        OP_SUBJ = 2'b11
    } cop_e;

    // Per-lane selection of the second operand's addend
    typedef struct packed {
        logic use_im;   // take imaginary part of operand 2
        logic neg;      // negate it before the sum
    } lane_ctl_t;

    // Real lane: +re, -re, -im, +im
    function automatic lane_ctl_t re_lane_ctl(input cop_e op);
        lane_ctl_t c;
        case (op)
            OP_ADD:  c = '{use_im: 1'b0, neg: 1'b0};
            OP_SUB:  c = '{use_im: 1'b0, neg: 1'b1};
            OP_ADDJ: c = '{use_im: 1'b1, neg: 1'b1};
            default: c = '{use_im: 1'b1, neg: 1'b0};
        endcase
        return c;
    endfunction

    // Imaginary lane: +im, -im, +re, -re
    function automatic lane_ctl_t im_lane_ctl(input cop_e op);
        lane_ctl_t c;
        case (op)
            OP_ADD:  c = '{use_im: 1'b1, neg: 1'b0};
            OP_SUB:  c = '{use_im: 1'b1, neg: 1'b1};
            OP_ADDJ: c = '{use_im: 1'b0, neg: 1'b0};
            default: c = '{use_im: 1'b0, neg: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/operand_lane_sel.sv
module operand_lane_sel
    import cplx_pkg::*;
#(
    parameter int W = cplx_pkg::DW
) (
    input  logic signed [W-1:0] b_re,
    input  logic signed [W-1:0] b_im,
    input  lane_ctl_t           ctl,
    output logic signed [W:0]   term
);
    logic signed [W-1:0] src;
    logic signed [W:0]   ext;

    always_comb begin
        src  = ctl.use_im ? b_im : b_re;
        ext  = {src[W-1], src};
        // one extra bit keeps -(most negative) representable
        term = ctl.neg ? -ext : ext;
    end
endmodule

// File: rtl/sat_add.sv
module sat_add #(
    parameter int W = cplx_pkg::DW
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W:0]   t,
    output logic signed [W-1:0] y,
    output logic                sat
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] sum;

    always_comb begin
        sum = {a[W-1], a} + t;
        sat = sum[W] ^ sum[W-1];
        if (!sat)
            y = sum[W-1:0];
        else if (sum[W])
            y = MINV;
        else
            y = MAXV;
    end
endmodule

// File: rtl/cplx_addsub_rot.sv
module cplx_addsub_rot
    import cplx_pkg::*;
#(
    parameter int W       = cplx_pkg::DW,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          op,
    input  logic signed [W-1:0] real_1,
    input  logic signed [W-1:0] imag_1,
    input  logic signed [W-1:0] real_2,
    input  logic signed [W-1:0] imag_2,
    output logic signed [W-1:0] real_out,
    output logic signed [W-1:0] imag_out,
    output logic                overflow,
    output logic                out_valid
);
    localparam int NLANE = 2;
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W-1:0] a_lane   [NLANE];
    lane_ctl_t           ctl_lane [NLANE];
    logic signed [W:0]   term     [NLANE];
    logic signed [W-1:0] res      [NLANE];
    logic                sat      [NLANE];
    logic                ovf_c;

    assign a_lane[0]   = real_1;
    assign a_lane[1]   = imag_1;
    assign ctl_lane[0] = re_lane_ctl(cop_e'(op));
    assign ctl_lane[1] = im_lane_ctl(cop_e'(op));

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        operand_lane_sel #(.W(W)) u_sel (
            .b_re (real_2),
            .b_im (imag_2),
            .ctl  (ctl_lane[g]),
            .term (term[g])
        );
        sat_add #(.W(W)) u_add (
            .a   (a_lane[g]),
            .t   (term[g]),
            .y   (res[g]),
            .sat (sat[g])
        );
    end

    assign ovf_c = sat[0] | sat[1];

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                real_out  <= '0;
                imag_out  <= '0;
                overflow  <= 1'b0;
                out_valid <= 1'b0;
            end else begin
                real_out  <= res[0];
                imag_out  <= res[1];
                overflow  <= ovf_c;
                out_valid <= in_valid;
            end
        end

        // R8
        valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (out_valid == $past(in_valid)));

        // R9
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (real_out == '0 && imag_out == '0 && !overflow && !out_valid));

        // R7
        ovf_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
            overflow |-> (real_out == MAXV || real_out == MINV ||
                          imag_out == MAXV || imag_out == MINV));

        // R1
        add_real_chk: assert property (@(posedge clk) disable iff (rst)
            (op == 2'b00) |=> (overflow || real_out == $past(real_1) + $past(real_2)));

        // R3
        addj_imag_chk: assert property (@(posedge clk) disable iff (rst)
            (op == 2'b10) |=> (overflow || imag_out == $past(imag_1) + $past(real_2)));
    end else begin : g_comb
        assign real_out  = res[0];
        assign imag_out  = res[1];
        assign overflow  = ovf_c;
        assign out_valid = in_valid;
    end
endmodule

// File: tb/cplx_addsub_rot_test.sv
`timescale 1ns/1ps
module cplx_addsub_rot_test;
    localparam int W    = 20;
    localparam int MAXV = 524287;
    localparam int MINV = -524288;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [1:0] op = 2'b00;
    logic signed [W-1:0] real_1 = '0, imag_1 = '0, real_2 = '0, imag_2 = '0;
    logic signed [W-1:0] real_out, imag_out;
    logic overflow, out_valid;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cplx_addsub_rot uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .real_1(real_1), .imag_1(imag_1), .real_2(real_2), .imag_2(imag_2),
        .real_out(real_out), .imag_out(imag_out),
        .overflow(overflow), .out_valid(out_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int corner(input int i);
        case (i)
            0: return MINV;
            1: return MINV + 1;
            2: return -1;
            3: return 0;
            4: return 1;
            5: return 300000;
            6: return MAXV - 1;
            default: return MAXV;
        endcase
    endfunction

    function automatic int clampv(input int v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    function automatic string tag_of(input int raw, input string optag);
        if (raw > MAXV) return "R5";
        if (raw < MINV) return "R6";
        return optag;
    endfunction

    int    e_re_raw, e_im_raw, e_valid;
    string e_tag;
    bit    have_prev;

    task automatic check_prev();
        chk(tag_of(e_re_raw, e_tag), int'(real_out), clampv(e_re_raw));
        chk(tag_of(e_im_raw, e_tag), int'(imag_out), clampv(e_im_raw));
        // R7 overflow reflects either clamp
        chk("R7", int'(overflow),
            int'(e_re_raw != clampv(e_re_raw) || e_im_raw != clampv(e_im_raw)));
        // R8 valid follows input one edge later
        chk("R8", int'(out_valid), e_valid);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        cnt = 0;
        have_prev = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", int'(real_out), 0);
        chk("R9", int'(imag_out), 0);
        chk("R9", int'(overflow), 0);
        chk("R9", int'(out_valid), 0);
        rst = 1'b0;

        for (int o = 0; o < 4; o++)
        for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
        for (int ic = 0; ic < 8; ic++)
        for (int id = 0; id < 8; id++) begin
            int r1, i1, r2, i2;
            r1 = corner(ia); i1 = corner(ib); r2 = corner(ic); i2 = corner(id);
            if (have_prev) check_prev();
            op       = 2'(o);
            real_1   = W'(r1);
            imag_1   = W'(i1);
            real_2   = W'(r2);
            imag_2   = W'(i2);
            in_valid = (cnt % 5) != 0;
            cnt++;
            case (o)
                0: begin e_re_raw = r1 + r2; e_im_raw = i1 + i2; e_tag = "R1"; end
                1: begin e_re_raw = r1 - r2; e_im_raw = i1 - i2; e_tag = "R2"; end
                2: begin e_re_raw = r1 - i2; e_im_raw = i1 + r2; e_tag = "R3"; end
                default: begin e_re_raw = r1 + i2; e_im_raw = i1 - r2; e_tag = "R4"; end
            endcase
            e_valid   = int'(in_valid);
            have_prev = 1;
            @(negedge clk);
        end
        check_prev();

        // R10 negation of the most negative value saturates
        op = 2'b01; real_1 = '0; imag_1 = '0; real_2 = W'(MINV); imag_2 = '0;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R10", int'(real_out), MAXV);
        chk("R10", int'(overflow), 1);
        op = 2'b11; real_2 = W'(MINV); imag_2 = '0; imag_1 = '0;
        @(negedge clk);
        chk("R10", int'(imag_out), MAXV);
        chk("R10", int'(real_out), 0);

        // R9 reset in mid-run clears a non-zero result
        rst = 1'b1;
        @(negedge clk);
        chk("R9", int'(imag_out), 0);
        chk("R9", int'(overflow), 0);
        chk("R9", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule